// File: doc/BRIEF.md
# Double-Buffered Serial Converter Input Register

This block is the digital front end of a serially loaded 12-bit converter. A host drives three wires: a data line, a serial clock and an active-low load strobe. Each rising edge of the serial clock pushes one data bit into a shift register, most significant bit first. A separate holding register presents a parallel code to the converter core.

The two registers are controlled independently. The shift register can take in a new word while the holding register keeps presenting the previous code. While the strobe is low, the holding register follows the shift register. When the strobe goes high, the holding register keeps the value it had at that moment.

All three host wires are brought into the block's own clock domain through a synchronizer of `SYNC_STAGES` flops. The serial clock's rising edge is found by edge detection in that domain. The holding register is run by a two-state control machine. In state `ST_HOLD` (strobe high) the code is frozen. In state `ST_TRACK` (strobe low) the code is refreshed from the shift register every cycle. There are two transitions: `HOLD->TRACK` when the synchronized strobe is low, and `TRACK->HOLD` when it is high. An asynchronous active-low reset clears both registers to zero, which is the zero-scale code, and puts the machine in `ST_HOLD`.

Top module: `sdac_front`

## Requirements
- R1: While `rst_n` is low, both registers are cleared to 12'h000 and `code` reads 12'h000. A load issued after reset, with no bits shifted in, also yields 12'h000.
- R2: A bit is sampled only on a rising edge of `sclk`. Changing `sdi` while `sclk` is high, or letting `sclk` fall, does not shift anything in.
- R3: Words are shifted most significant bit first. After exactly 12 bits and a load, `code[11]` equals the first bit sent and `code[0]` equals the last.
- R4: If more than 12 bits are shifted in before a load, the earliest extra bits are discarded, and the last 12 bits received form the code.
- R5: While `ld_n` is low, `code` follows the shift register: each newly shifted value appears on `code`.
- R6: While `ld_n` is high, `code` holds its value, even while a new word is being shifted in.
- R7: When `ld_n` returns high, `code` keeps the value it had at that moment, and later shifting does not change it.
- R8: `code` is a register output. Toggling `sdi` while `sclk` does not rise leaves `code` unchanged, even while `ld_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host; data sampled on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| ld_n | input | 1 | Active-low level-sensitive load strobe |
| code | output | CODE_W (12) | Parallel code from the holding register to the converter core |

## Verification
The bench targets bursts longer than 12 bits. A design that kept the first bits instead of the last would load a stale, shifted word. It also changes `sdi` while `sclk` is high and then lets `sclk` fall. A design that sampled on both edges, or on the falling edge, would take in the wrong bit. The strobe is held low during shifting to confirm that every intermediate value reaches `code`. The strobe is then released and more bits are shifted. This catches a design that keeps tracking or reloads on the strobe edge. Bit order is checked with asymmetric words, where a reversed register would produce a different code.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int unsigned CODE_W_DEF = 12;
    localparam int unsigned SYNC_DEF   = 2;

    typedef enum logic {
        ST_HOLD  = 1'b0,
        ST_TRACK = 1'b1
    } load_state_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= RESET_VAL;
                end else if (s == 0) begin
                    chain_q[s] <= din;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             sdi_s,
    output logic [WIDTH-1:0] shift_o
);
    logic             sclk_prev_q;
    logic             rise;
    logic [WIDTH-1:0] shift_q;

    assign rise = sclk_s & ~sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            shift_q     <= '0;
        end else begin
            sclk_prev_q <= sclk_s;
            if (rise) begin
                shift_q <= {shift_q[WIDTH-2:0], sdi_s};
            end
        end
    end

    assign shift_o = shift_q;

    // R2
    shift_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_s || sclk_prev_q) |=> $stable(shift_q));
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold
    import sdac_pkg::*;
#(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_s_n,
    input  logic [WIDTH-1:0] shift_i,
    output logic [WIDTH-1:0] code_o
);
    load_state_e      state_q, state_d;
    logic [WIDTH-1:0] code_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (!ld_s_n) state_d = ST_TRACK;
            ST_TRACK: if (ld_s_n)  state_d = ST_HOLD;
            default:  state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            unique case (state_q)
                ST_TRACK: code_q <= shift_i;
                ST_HOLD:  code_q <= code_q;
                default:  code_q <= code_q;
            endcase
        end
    end

    assign code_o = code_q;

    // R6
    hold_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(code_q));

    // R5
    track_follows_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK) |=> (code_q == $past(shift_i)));
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int unsigned CODE_W      = CODE_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              ld_n,
    output logic [CODE_W-1:0] code
);
    logic              sclk_s;
    logic              sdi_s;
    logic              ld_s_n;
    logic [CODE_W-1:0] shift_w;

    sdac_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s));
    sdac_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .din(sdi), .dout(sdi_s));
    sdac_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_ld (
        .clk(clk), .rst_n(rst_n), .din(ld_n), .dout(ld_s_n));

    sdac_shift #(.WIDTH(CODE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .shift_o(shift_w));

    sdac_hold #(.WIDTH(CODE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .ld_s_n(ld_s_n), .shift_i(shift_w),
        .code_o(code));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (code == '0 && shift_w == '0));

    // R7
    strobe_high_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s_n && $past(ld_s_n)) |=> $stable(code));
endmodule

// File: tb/sdac_front_tb_top.sv
module sdac_front_tb_top;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic         ld_n = 1'b1;
    logic [W-1:0] code;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] model = '0;
    logic [W-1:0] frozen;

    always #4 clk = ~clk;

    sdac_front dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi),
                      .ld_n(ld_n), .code(code));

    function automatic logic [W-1:0] shift_model(input logic [W-1:0] m, input logic b);
        return {m[W-2:0], b};
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk); sdi = b;
        wait_n(5); sclk = 1'b1;
        wait_n(5); sclk = 1'b0;
        wait_n(5);
        model = shift_model(model, b);
    endtask

    task automatic load_pulse();
        @(negedge clk); ld_n = 1'b0;
        wait_n(8); ld_n = 1'b1;
        wait_n(8);
    endtask

    initial begin
        #1_600_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_n(3);
        // R1 reset state
        chk("R1 code during reset", code, 12'h000);
        rst_n = 1'b1;
        wait_n(3);
        load_pulse();
        chk("R1 load after reset", code, 12'h000);

        // R3 MSB first, asymmetric word
        for (int i = W-1; i >= 0; i--) put_bit(1'(12'hC35 >> i));
        chk("R6 code held before load", code, 12'h000);
        load_pulse();
        chk("R3 msb first", code, 12'hC35);

        // R4 extra leading bits discarded
        for (int i = 0; i < 5; i++) put_bit(1'b1);
        for (int i = W-1; i >= 0; i--) put_bit(1'(12'h016 >> i));
        load_pulse();
        chk("R4 last 12 bits kept", code, 12'h016);

        // R2 data change while sclk high, then falling edge
        @(negedge clk); sdi = 1'b1;
        wait_n(5); sclk = 1'b1;
        wait_n(5); sdi = 1'b0;
        wait_n(5); sclk = 1'b0;
        wait_n(5); sdi = 1'b1;
        wait_n(5);
        model = shift_model(model, 1'b1);
        load_pulse();
        chk("R2 rising edge sample only", code, model);

        // R5 tracking with strobe low
        @(negedge clk); ld_n = 1'b0;
        wait_n(6);
        for (int i = 0; i < 14; i++) begin
            put_bit(1'($urandom_range(0, 1)));
            chk("R5 tracks shift register", code, model);
        end

        // R8 sdi toggle without sclk edge
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); sdi = ~sdi;
            wait_n(3);
        end
        wait_n(5);
        chk("R8 no change without sclk edge", code, model);

        // R7 release keeps value
        frozen = model;
        @(negedge clk); ld_n = 1'b1;
        wait_n(8);
        for (int i = 0; i < 7; i++) put_bit(1'($urandom_range(0, 1)));
        chk("R7 value kept after release", code, frozen);

        // R6 random words with random leading extras
        for (int n = 0; n < 20; n++) begin
            logic [W-1:0] w;
            int extra;
            w = W'($urandom);
            extra = $urandom_range(0, 6);
            frozen = code;
            for (int i = 0; i < extra; i++) put_bit(1'($urandom_range(0, 1)));
            for (int i = W-1; i >= 0; i--) put_bit(w[i]);
            chk("R6 code holds while shifting", code, frozen);
            load_pulse();
            chk("R4 random word load", code, w);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule